// File: doc/BRIEF.md
# Gigabit Transmit Code-Group Framer

This block sits between a byte-wide gigabit MAC transmit port (enable, error, eight data bits per clock) and an 8B/10B encoder. Every clock it issues one code-group request: a control flag, an eight-bit value, and a flag that forces the encoder to emit an invalid code group. It wraps each frame into the ordered sets a 1000BASE-X link expects. Between frames it sends idle pairs. At a frame start it puts the start delimiter in place of the first preamble byte, and at a frame end it sends the end delimiter and carrier-extend padding. It also handles false carrier and error propagation.

The framer counts even and odd code-group positions from reset. The idle comma and the start delimiter are only ever placed on an even position. When a frame begins on an odd position, the framer finishes the idle pair first and runs the whole frame one clock later through a single holding register. After each frame, the encoder's running-disparity input selects which idle form comes first.

Top module: `gx_tx_framer`

## Requirements
- R1: With no frame in progress, the output alternates a comma (control, 0xBC) on even positions and an odd idle half (data 0x50, or 0xC5 as in R2) on odd positions. Until the first frame ends, every odd idle half is 0x50.
- R2: The odd half of the first idle pair after a frame is 0xC5 if `rd_pos` was high in the clock before that pair's comma appears, and 0x50 otherwise. Later idle pairs use 0x50 whatever `rd_pos` does.
- R3: After reset the output shows an even-position comma (k=1, value 0xBC, err=0, `cg_even`=1). From then on `cg_even` toggles every clock.
- R4: The first clock with `tx_en` high is replaced by the start delimiter (control, 0xFB) on an even position. If that clock is itself followed by an even position, the start appears one clock later. The following bytes appear in order as data code groups, one per clock.
- R5: If the position following the first `tx_en` clock is odd, the idle pair is completed first. The start delimiter then appears two clocks after that first `tx_en` clock, and every later byte of the frame is also delayed by two clocks.
- R6: A minimal preamble of one 0x55 byte followed by 0xD5 is accepted: it yields the start delimiter, then data 0xD5.
- R7: If `tx_er` is high in the first `tx_en` clock, an error code group (err=1, k=0, value 0x00) is sent in place of the start delimiter.
- R8: During a frame, every byte clock with `tx_er` high yields the error code group instead of the byte.
- R9: When `tx_en` falls, one end delimiter (control, 0xFD) follows the last byte, then carrier extend (control, 0xF7). A second 0xF7 is added exactly when the first one sits on an even position, so the next comma falls on an even position.
- R10: `tx_er` has no effect while `tx_en` is low: between frames, and in the clock where `tx_en` falls, the output is the same as with `tx_er` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Frame enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| tx_d | input | 8 | Transmit byte from the MAC |
| rd_pos | input | 1 | Encoder running disparity is positive |
| cg_k | output | 1 | Code group is a control character |
| cg_err | output | 1 | Force an invalid code group |
| cg_val | output | 8 | Code-group byte value |
| cg_even | output | 1 | Code group occupies an even position |

## Verification
The bench builds the block at its default eight-bit byte width, which is also the only width the code-group constants are defined for. Frames must keep `tx_en` low for at least four clocks between them. The bench uses gaps of six to twelve clocks, with random `tx_er` noise in every gap, and varies the gap length so that frames start on both even and odd positions. That covers the held-frame path as well as both the one-extend and the two-extend endings. Random `rd_pos` on every clock checks that only the first idle pair after each frame follows the disparity input.

// File: rtl/gx_tx_pkg.sv
`timescale 1ns/1ps
package gx_tx_pkg;
  localparam int CG_BITS = 8;

  typedef struct packed {
    logic               k;
    logic               err;
    logic [CG_BITS-1:0] val;
  } cg_t;

  localparam logic [CG_BITS-1:0] CG_COMMA     = 8'hBC;
  localparam logic [CG_BITS-1:0] CG_ODD_FIX   = 8'hC5;
  localparam logic [CG_BITS-1:0] CG_ODD_KEEP  = 8'h50;
  localparam logic [CG_BITS-1:0] CG_SOP       = 8'hFB;
  localparam logic [CG_BITS-1:0] CG_EOP       = 8'hFD;
  localparam logic [CG_BITS-1:0] CG_EXTEND    = 8'hF7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_FRAME, SQ_EXT_A, SQ_EXT_B} sq_state_t;

  function automatic cg_t cg_ctrl(input logic [CG_BITS-1:0] v);
    cg_t c;
    c.k = 1'b1; c.err = 1'b0; c.val = v;
    return c;
  endfunction

  function automatic cg_t cg_data(input logic [CG_BITS-1:0] v);
    cg_t c;
    c.k = 1'b0; c.err = 1'b0; c.val = v;
    return c;
  endfunction

  function automatic cg_t cg_void();
    cg_t c;
    c.k = 1'b0; c.err = 1'b1; c.val = '0;
    return c;
  endfunction

  function automatic cg_t cg_idle_odd(input logic fix_rd);
    return cg_data(fix_rd ? CG_ODD_FIX : CG_ODD_KEEP);
  endfunction

  // One extend on an odd slot already closes the pair; on an even slot a second is needed.
  function automatic logic ext_needs_second(input logic ext_slot_even);
    return ext_slot_even;
  endfunction
endpackage

// File: rtl/gx_tx_hold.sv
`timescale 1ns/1ps
module gx_tx_hold #(
  parameter int DW = gx_tx_pkg::CG_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_en,
  input  logic          in_er,
  input  logic [DW-1:0] in_d,
  input  logic          use_held,
  output logic          sel_en,
  output logic          sel_er,
  output logic [DW-1:0] sel_d
);
  logic          h_en, h_er;
  logic [DW-1:0] h_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_en <= 1'b0;
      h_er <= 1'b0;
      h_d  <= '0;
    end else begin
      h_en <= in_en;
      h_er <= in_er;
      h_d  <= in_d;
    end
  end

  always_comb begin
    sel_en = use_held ? h_en : in_en;
    sel_er = use_held ? h_er : in_er;
    sel_d  = use_held ? h_d  : in_d;
  end
endmodule

// File: rtl/gx_tx_seq.sv
`timescale 1ns/1ps
module gx_tx_seq
  import gx_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_en,
  input  logic               sel_er,
  input  logic [CG_BITS-1:0] sel_d,
  input  logic               live_en,
  input  logic               rd_pos,
  output cg_t                nxt_cg,
  output logic               nxt_even,
  output logic               use_held,
  output logic               sof_evt,
  output logic               lag_set_evt,
  output logic               eof_evt
);
  sq_state_t st_q, st_n;
  logic slot_even_q, lag_q, lag_n, first_q, first_n, fix_q, fix_n;

  assign nxt_even = slot_even_q;
  assign use_held = lag_q;

  always_comb begin
    st_n        = st_q;
    lag_n       = lag_q;
    first_n     = first_q;
    fix_n       = fix_q;
    nxt_cg      = cg_ctrl(CG_COMMA);
    sof_evt     = 1'b0;
    lag_set_evt = 1'b0;
    eof_evt     = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (slot_even_q) begin
          if (sel_en) begin
            sof_evt = 1'b1;
            nxt_cg  = sel_er ? cg_void() : cg_ctrl(CG_SOP);
            st_n    = SQ_FRAME;
            first_n = 1'b0;
          end else begin
            nxt_cg  = cg_ctrl(CG_COMMA);
            fix_n   = first_q & rd_pos;
            first_n = 1'b0;
          end
        end else begin
          nxt_cg = cg_idle_odd(fix_q);
          if (live_en && !lag_q) begin
            lag_n       = 1'b1;
            lag_set_evt = 1'b1;
          end
        end
      end
      SQ_FRAME: begin
        if (sel_en) begin
          nxt_cg = sel_er ? cg_void() : cg_data(sel_d);
        end else begin
          nxt_cg  = cg_ctrl(CG_EOP);
          eof_evt = 1'b1;
          st_n    = SQ_EXT_A;
        end
      end
      SQ_EXT_A: begin
        nxt_cg = cg_ctrl(CG_EXTEND);
        if (ext_needs_second(slot_even_q)) begin
          st_n = SQ_EXT_B;
        end else begin
          st_n    = SQ_IDLE;
          lag_n   = 1'b0;
          first_n = 1'b1;
        end
      end
      default: begin
        nxt_cg  = cg_ctrl(CG_EXTEND);
        st_n    = SQ_IDLE;
        lag_n   = 1'b0;
        first_n = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= SQ_IDLE;
      slot_even_q <= 1'b0;
      lag_q       <= 1'b0;
      first_q     <= 1'b0;
      fix_q       <= 1'b0;
    end else begin
      st_q        <= st_n;
      slot_even_q <= ~slot_even_q;
      lag_q       <= lag_n;
      first_q     <= first_n;
      fix_q       <= fix_n;
    end
  end

  // R5: a held start always produces the start event on the next slot
  a_r5_held_start: assert property (@(posedge clk) disable iff (rst)
    lag_set_evt |=> sof_evt);
  // R9: an end event is never followed by another end event on the next slot
  a_r9_single_eop: assert property (@(posedge clk) disable iff (rst)
    eof_evt |=> !eof_evt && !sof_evt);
endmodule

// File: rtl/gx_tx_cgreg.sv
`timescale 1ns/1ps
module gx_tx_cgreg
  import gx_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  cg_t                nxt_cg,
  input  logic               nxt_even,
  output logic               cg_k,
  output logic               cg_err,
  output logic [CG_BITS-1:0] cg_val,
  output logic               cg_even
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cg_k    <= 1'b1;
      cg_err  <= 1'b0;
      cg_val  <= CG_COMMA;
      cg_even <= 1'b1;
    end else begin
      cg_k    <= nxt_cg.k;
      cg_err  <= nxt_cg.err;
      cg_val  <= nxt_cg.val;
      cg_even <= nxt_even;
    end
  end
endmodule

// File: rtl/gx_tx_framer.sv
`timescale 1ns/1ps
module gx_tx_framer
  import gx_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_en,
  input  logic               tx_er,
  input  logic [CG_BITS-1:0] tx_d,
  input  logic               rd_pos,
  output logic               cg_k,
  output logic               cg_err,
  output logic [CG_BITS-1:0] cg_val,
  output logic               cg_even
);
  logic               s_en, s_er, held, nx_even;
  logic [CG_BITS-1:0] s_d;
  logic               sof_evt, lag_set_evt, eof_evt;
  cg_t                nx_cg;

  gx_tx_hold #(.DW(CG_BITS)) u_hold (
    .clk(clk), .rst(rst), .in_en(tx_en), .in_er(tx_er), .in_d(tx_d),
    .use_held(held), .sel_en(s_en), .sel_er(s_er), .sel_d(s_d)
  );

  gx_tx_seq u_seq (
    .clk(clk), .rst(rst), .sel_en(s_en), .sel_er(s_er), .sel_d(s_d),
    .live_en(tx_en), .rd_pos(rd_pos), .nxt_cg(nx_cg), .nxt_even(nx_even),
    .use_held(held), .sof_evt(sof_evt), .lag_set_evt(lag_set_evt), .eof_evt(eof_evt)
  );

  gx_tx_cgreg u_out (
    .clk(clk), .rst(rst), .nxt_cg(nx_cg), .nxt_even(nx_even),
    .cg_k(cg_k), .cg_err(cg_err), .cg_val(cg_val), .cg_even(cg_even)
  );

  logic is_comma, is_ext, is_eop, is_sop;
  assign is_comma = cg_k && !cg_err && cg_val == CG_COMMA;
  assign is_ext   = cg_k && !cg_err && cg_val == CG_EXTEND;
  assign is_eop   = cg_k && !cg_err && cg_val == CG_EOP;
  assign is_sop   = cg_k && !cg_err && cg_val == CG_SOP;

  a_r1_comma_even: assert property (@(posedge clk) disable iff (rst)
    is_comma |-> cg_even);
  a_r1_idle_pair: assert property (@(posedge clk) disable iff (rst)
    is_comma |=> (!cg_k && !cg_err && (cg_val == CG_ODD_FIX || cg_val == CG_ODD_KEEP)));
  a_r3_alternate: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cg_even != $past(cg_even));
  a_r4_sop_even: assert property (@(posedge clk) disable iff (rst)
    is_sop |-> cg_even);
  a_r9_eop_then_ext: assert property (@(posedge clk) disable iff (rst)
    is_eop |=> is_ext);
  a_r9_ext_closes: assert property (@(posedge clk) disable iff (rst)
    is_ext |=> (is_ext || (is_comma && cg_even)));
  a_r9_ext_max_two: assert property (@(posedge clk) disable iff (rst)
    (is_ext && $past(is_ext)) |=> !is_ext);
endmodule

// File: tb/gx_tx_framer_test.sv
`timescale 1ns/1ps
module gx_tx_framer_test;
  localparam int NC = 2400;

  bit clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, en, er, rd;
  logic [7:0] d;
  logic       cg_k, cg_err, cg_even;
  logic [7:0] cg_val;

  gx_tx_framer uut (
    .clk(clk), .rst(rst), .tx_en(en), .tx_er(er), .tx_d(d), .rd_pos(rd),
    .cg_k(cg_k), .cg_err(cg_err), .cg_val(cg_val), .cg_even(cg_even)
  );

  bit           drv_en [NC];
  bit           drv_er [NC];
  bit           drv_rd [NC];
  byte unsigned drv_d  [NC];
  bit           ex_k   [NC];
  bit           ex_e   [NC];
  byte unsigned ex_v   [NC];
  byte unsigned ex_r   [NC];
  int  checks = 0, errors = 0;
  bit  done = 1'b0;

  function automatic string rname(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  function automatic int first_even_after(input int s);
    return ((s + 1) % 2 == 0) ? s + 1 : s + 2;
  endfunction

  task automatic put(input int j, input bit k, input bit e, input byte unsigned v, input int r);
    if (j < NC) begin
      ex_k[j] = k; ex_e[j] = e; ex_v[j] = v; ex_r[j] = byte'(r);
    end
  endtask

  // kind 1 = minimal preamble; returns nothing, fills drive and expected arrays
  task automatic plan_frame(input int s, input int len, input int kind, input bit fc, input bit er_tail);
    int st, t, ie;
    bit lagged;
    st = first_even_after(s);
    lagged = (st == s + 2);
    for (int i = 0; i < len; i++) begin
      bit eb;
      byte unsigned db;
      db = (i == 0) ? 8'h55 : (kind == 1 && i == 1) ? 8'hD5 : byte'($urandom % 256);
      eb = (i == 0) ? fc : (kind == 1) ? 1'b0 : ($urandom % 8 == 0);
      drv_en[s+i] = 1'b1; drv_er[s+i] = eb; drv_d[s+i] = db;
      if (eb)          put(st+i, 1'b0, 1'b1, 8'h00, (i == 0) ? 7 : 8);
      else if (i == 0) put(st+i, 1'b1, 1'b0, 8'hFB, lagged ? 5 : 4);
      else             put(st+i, 1'b0, 1'b0, db, (kind == 1) ? 6 : 4);
    end
    drv_er[s+len] = er_tail;
    t = st + len;
    put(t, 1'b1, 1'b0, 8'hFD, 9);
    put(t+1, 1'b1, 1'b0, 8'hF7, 9);
    if ((t + 1) % 2 == 0) begin
      put(t+2, 1'b1, 1'b0, 8'hF7, 9);
      ie = t + 3;
    end else begin
      ie = t + 2;
    end
    put(ie, 1'b1, 1'b0, 8'hBC, 10);
    put(ie+1, 1'b0, 1'b0, drv_rd[ie-1] ? 8'hC5 : 8'h50, 2);
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * (NC + 200));
    if (!done) begin
      checks++; errors++;
      $display("FAIL R3 watchdog: reached cycle actual none, expected %0d", NC);
      finish_run();
    end
  end

  initial begin
    int cyc;
    int f;
    void'($urandom(32'd2718));
    for (int j = 0; j < NC; j++) begin
      drv_en[j] = 1'b0;
      drv_er[j] = ($urandom % 2 == 1);
      drv_d[j]  = byte'($urandom % 256);
      drv_rd[j] = ($urandom % 2 == 1);
      put(j, (j % 2 == 0), 1'b0, (j % 2 == 0) ? 8'hBC : 8'h50, 1);
    end
    ex_r[0] = 3;
    // directed: even start, held odd start, minimal preamble, false carrier, one-byte frame
    cyc = 9;   plan_frame(cyc, 8, 0, 1'b0, 1'b1); cyc += 8 + 8;
    if (cyc % 2 == 1) cyc++;
    plan_frame(cyc, 6, 0, 1'b0, 1'b0); cyc += 6 + 7;
    plan_frame(cyc, 2, 1, 1'b0, 1'b1); cyc += 2 + 6;
    plan_frame(cyc, 5, 0, 1'b1, 1'b0); cyc += 5 + 9;
    plan_frame(cyc, 1, 0, 1'b0, 1'b1); cyc += 1 + 6;
    f = 0;
    while (cyc + 40 < NC) begin
      int len, gap;
      len = 1 + int'($urandom % 20);
      gap = 6 + int'($urandom % 7);
      plan_frame(cyc, len, 0, ($urandom % 6 == 0), ($urandom % 2 == 1));
      cyc += len + gap;
      f++;
    end

    rst = 1'b1; en = 1'b0; er = 1'b0; d = 8'h00; rd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < NC; c++) begin
      if (c > 0) @(negedge clk);
      checks++;
      if (cg_even !== (c % 2 == 0)) begin
        errors++;
        $display("FAIL R3 slot %0d parity: actual %0b expected %0b", c, cg_even, (c % 2 == 0));
      end
      checks++;
      if (cg_k !== ex_k[c] || cg_err !== ex_e[c] || cg_val !== ex_v[c]) begin
        errors++;
        $display("FAIL %s slot %0d: actual k=%0b err=%0b val=%02h expected k=%0b err=%0b val=%02h",
                 rname(ex_r[c]), c, cg_k, cg_err, cg_val, ex_k[c], ex_e[c], ex_v[c]);
      end
      en = drv_en[c]; er = drv_er[c]; d = drv_d[c]; rd = drv_rd[c];
    end
    done = 1'b1;
    finish_run();
  end
endmodule